// File: doc/BRIEF.md
# Page-Bounded Transfer Segmenter

This block takes one DMA transfer, given as a starting physical address, a second page pointer and a byte length, and cuts it into segments that never cross a page boundary. Each segment (address, length) is offered on a valid/ready output. The first segment may start anywhere in a page. Every later segment starts on a page boundary and takes its address from a page pointer.

When the transfer ends within the first page plus one more page, the second pointer is the data address of that page. Otherwise the second pointer addresses a list of 8-byte page pointers, which the block reads one at a time through a request/response read port. When a list page has only its final slot left and more than one page of data remains, that slot holds the address of the next list page, and reading continues there. A pointer that breaks the alignment rules ends the sequence with an error pulse, and no further segments follow. A done pulse marks the normal end.

Back-pressure: a segment stays on `seg_addr`/`seg_len` with `seg_valid` high until a cycle in which `seg_ready` is high. A list read request stays on `lrd_req_addr` with `lrd_req_valid` high until `lrd_req_ready` is high. Exactly one response, `lrd_rsp_valid` for one cycle, is expected per accepted request.

Top module: `prp_segmenter`

## Requirements
- R1: A first pointer with either of its two low bits set makes `err` pulse for one cycle after `start`, and no segment is produced.
- R2: The first segment has the first pointer as its address, and its length is the smaller of the transfer length and the bytes from that address to the end of its page.
- R3: No segment crosses a page boundary. Every segment after the first has a page offset of zero and a length equal to the smaller of one page and the bytes still remaining.
- R4: If the bytes left after the first segment are at most one page, the second pointer is used directly as the address of the final segment.
- R5: If more than one page remains after the first segment, the second pointer is a list address. It must have its three low bits clear. List entries are read at that address and then at ascending 8-byte steps, and each entry is the address of the next data segment.
- R6: An entry read from the last 8-byte slot of a page (page offset equal to page size minus 8) while more than one page of data remains is the address of the next list page. Reading resumes there, and that entry produces no segment.
- R7: A data pointer from the second field or from a list with a nonzero page offset, or a list or chain address with any of its three low bits set, makes `err` pulse. The block returns to idle, and no further segment follows.
- R8: `done` pulses for one cycle, in the cycle after the handshake of the segment that brings the remaining length to zero. A zero transfer length gives `done` one cycle after `start`, with no segment.
- R9: A segment offer holds its valid and its address and length unchanged until it is accepted. A list read request holds its valid and its address until it is accepted.
- R10: `start` is ignored while `busy` is high, and the segments of the running transfer are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer when idle |
| ptr_first | input | ADDR_W | First page pointer, may be mid-page |
| ptr_second | input | ADDR_W | Second pointer: data page or list address |
| xfer_len | input | LEN_W | Transfer length in bytes |
| busy | output | 1 | A transfer is in progress |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| lrd_req_valid | output | 1 | List entry read request |
| lrd_req_ready | input | 1 | Read request accepted |
| lrd_req_addr | output | ADDR_W | Address of the list entry |
| lrd_rsp_valid | input | 1 | Read data returned |
| lrd_rsp_data | input | ADDR_W | The list entry read |
| done | output | 1 | Transfer finished normally |
| err | output | 1 | Transfer aborted on a bad pointer |

## Verification
The patterns cover transfers that fit inside the first page, that spill into exactly one more page, that end exactly at a page boundary, and that need a list. These separate direct use of the second pointer from list use, and the boundary compare at one page from an off-by-one. A list starting near the end of its page, and a list long enough to fill a whole page, force chaining both early and at the natural slot. Misaligned first, second, list and listed pointers, together with a start pulse during a running transfer, show that errors cut the output short and that a stray start is ignored. Random stalls on both handshakes and varied read latency test that outputs hold under back-pressure.

// File: rtl/prp_seg_pkg.sv
package prp_seg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEG   = 2'd1,
    ST_LREQ  = 2'd2,
    ST_LWAIT = 2'd3
  } seg_state_e;
endpackage

// File: rtl/prp_seg_sizer.sv
// Length of the segment at the current address and what is left after it.
module prp_seg_sizer #(
  parameter int LEN_W      = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic [OFF_W-1:0] cur_off,
  input  logic [LEN_W-1:0] rem,
  output logic [LEN_W-1:0] seg_len,
  output logic [LEN_W-1:0] rem_after,
  output logic             last,
  output logic             fits_next,
  output logic             rem_gt_page
);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  logic [LEN_W-1:0] room;

  always_comb begin
    room        = PAGE_L - {{(LEN_W-OFF_W){1'b0}}, cur_off};
    seg_len     = (rem < room) ? rem : room;
    rem_after   = rem - seg_len;
    last        = (rem_after == '0);
    fits_next   = (rem_after <= PAGE_L);
    rem_gt_page = (rem > PAGE_L);
  end
endmodule

// File: rtl/prp_ptr_check.sv
// Alignment test on the low bits of a pointer.
module prp_ptr_check #(
  parameter int CHK_BITS = 2
) (
  input  logic [CHK_BITS-1:0] low_bits,
  output logic                ok
);
  generate
    if (CHK_BITS > 0) begin : g_check
      assign ok = ~|low_bits;
    end else begin : g_none
      assign ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/prp_list_cursor.sv
// Address of the next list entry and detection of the final slot in a page.
module prp_list_cursor #(
  parameter int ADDR_W      = 64,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              last_slot
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - ENTRY_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_addr;
    else if (advance) addr <= addr + ADDR_W'(ENTRY_BYTES);
  end

  assign last_slot = (addr[OFF_W-1:0] == LAST_OFF);
endmodule

// File: rtl/prp_segmenter.sv
module prp_segmenter #(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_first,
  input  logic [ADDR_W-1:0] ptr_second,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              lrd_req_valid,
  input  logic              lrd_req_ready,
  output logic [ADDR_W-1:0] lrd_req_addr,
  input  logic              lrd_rsp_valid,
  input  logic [ADDR_W-1:0] lrd_rsp_data,
  output logic              done,
  output logic              err
);
  import prp_seg_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int ENT_W = $clog2(ENTRY_BYTES);
  localparam int DW_W  = 2;

  seg_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] ptr2_q, ptr2_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              first_q, first_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic [LEN_W-1:0]  sz_len, sz_rem_after;
  logic              sz_last, sz_fits_next, sz_gt_page;
  logic [ADDR_W-1:0] cand;
  logic              first_ok, data_ok, list_ok;
  logic              cur_load, cur_adv, cur_last_slot;

  prp_seg_sizer #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_sizer (
    .cur_off     (cur_q[OFF_W-1:0]),
    .rem         (rem_q),
    .seg_len     (sz_len),
    .rem_after   (sz_rem_after),
    .last        (sz_last),
    .fits_next   (sz_fits_next),
    .rem_gt_page (sz_gt_page)
  );

  // Pointer under test: the list response while waiting, else the second pointer.
  assign cand = (state_q == ST_LWAIT) ? lrd_rsp_data : ptr2_q;

  prp_ptr_check #(.CHK_BITS(DW_W)) u_chk_first (
    .low_bits (ptr_first[DW_W-1:0]),
    .ok       (first_ok)
  );

  prp_ptr_check #(.CHK_BITS(OFF_W)) u_chk_data (
    .low_bits (cand[OFF_W-1:0]),
    .ok       (data_ok)
  );

  prp_ptr_check #(.CHK_BITS(ENT_W)) u_chk_list (
    .low_bits (cand[ENT_W-1:0]),
    .ok       (list_ok)
  );

  prp_list_cursor #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cur_load),
    .load_addr (cand),
    .advance   (cur_adv),
    .addr      (lrd_req_addr),
    .last_slot (cur_last_slot)
  );

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    ptr2_d   = ptr2_q;
    rem_d    = rem_q;
    first_d  = first_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    cur_load = 1'b0;
    cur_adv  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (xfer_len == '0) begin
            done_d = 1'b1;
          end else if (!first_ok) begin
            err_d = 1'b1;
          end else begin
            cur_d   = ptr_first;
            ptr2_d  = ptr_second;
            rem_d   = xfer_len;
            first_d = 1'b1;
            state_d = ST_SEG;
          end
        end
      end
      ST_SEG: begin
        if (seg_ready) begin
          rem_d = sz_rem_after;
          if (sz_last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (first_q) begin
            first_d = 1'b0;
            if (sz_fits_next) begin
              if (data_ok) begin
                cur_d = ptr2_q;
              end else begin
                err_d   = 1'b1;
                state_d = ST_IDLE;
              end
            end else if (list_ok) begin
              cur_load = 1'b1;
              state_d  = ST_LREQ;
            end else begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            state_d = ST_LREQ;
          end
        end
      end
      ST_LREQ: begin
        if (lrd_req_ready) state_d = ST_LWAIT;
      end
      ST_LWAIT: begin
        if (lrd_rsp_valid) begin
          if (cur_last_slot && sz_gt_page) begin
            if (list_ok) begin
              cur_load = 1'b1;
              state_d  = ST_LREQ;
            end else begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end else if (data_ok) begin
            cur_d   = lrd_rsp_data;
            cur_adv = 1'b1;
            state_d = ST_SEG;
          end else begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ptr2_q  <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      ptr2_q  <= ptr2_d;
      rem_q   <= rem_d;
      first_q <= first_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign seg_valid     = (state_q == ST_SEG);
  assign seg_addr      = cur_q;
  assign seg_len       = sz_len;
  assign lrd_req_valid = (state_q == ST_LREQ);
  assign done          = done_q;
  assign err           = err_q;
endmodule

// File: rtl/prp_seg_checker.sv
module prp_seg_checker #(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int ENT_W      = $clog2(ENTRY_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              lrd_req_valid,
  input logic              lrd_req_ready,
  input logic [ADDR_W-1:0] lrd_req_addr,
  input logic              done,
  input logic              err
);
  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lrd_req_valid && !lrd_req_ready |=> lrd_req_valid && $stable(lrd_req_addr));

  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0) &&
      (({{(LEN_W-OFF_W){1'b0}}, seg_addr[OFF_W-1:0]} + seg_len) <= LEN_W'(PAGE_BYTES)));

  assert_dword_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_addr[1:0] == 2'b00);

  assert_list_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lrd_req_valid |-> lrd_req_addr[ENT_W-1:0] == '0);

  assert_end_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));

  assert_single_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !seg_valid && !lrd_req_valid);
endmodule

bind prp_segmenter prp_seg_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .ENTRY_BYTES(ENTRY_BYTES)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .seg_valid     (seg_valid),
  .seg_ready     (seg_ready),
  .seg_addr      (seg_addr),
  .seg_len       (seg_len),
  .lrd_req_valid (lrd_req_valid),
  .lrd_req_ready (lrd_req_ready),
  .lrd_req_addr  (lrd_req_addr),
  .done          (done),
  .err           (err)
);

// File: tb/prp_segmenter_tb.sv
`timescale 1ns/1ps
module prp_segmenter_tb_top;
  localparam int PAGE = 4096;
  localparam int MAXS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ptr_first = '0, ptr_second = '0;
  logic [31:0] xfer_len = '0;
  logic        busy, seg_valid, lrd_req_valid, done, err;
  logic        seg_ready = 1'b0, lrd_req_ready = 1'b0, lrd_rsp_valid = 1'b0;
  logic [63:0] seg_addr, lrd_req_addr, lrd_rsp_data = '0;
  logic [31:0] seg_len;

  always #2.5 clk = ~clk;

  prp_segmenter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_first(ptr_first),
    .ptr_second(ptr_second), .xfer_len(xfer_len), .busy(busy),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .lrd_req_valid(lrd_req_valid), .lrd_req_ready(lrd_req_ready),
    .lrd_req_addr(lrd_req_addr), .lrd_rsp_valid(lrd_rsp_valid),
    .lrd_rsp_data(lrd_rsp_data), .done(done), .err(err)
  );

  int total = 0, bad = 0, cyc = 0;
  logic finished = 1'b0;
  logic [63:0] poison_addr = '1;

  logic [63:0] exp_addr [MAXS];
  logic [31:0] exp_len  [MAXS];
  int          exp_n;
  logic        exp_err;
  logic [63:0] got_addr [MAXS];
  logic [31:0] got_len  [MAXS];
  int          got_n = 0, last_hs_cyc = 0, end_cyc = 0;
  logic        saw_done = 1'b0, saw_err = 1'b0;

  // List memory model: every entry is a page-aligned address derived from its location.
  function automatic logic [63:0] mem_at(input logic [63:0] a);
    logic [63:0] v;
    v = ((a << 4) + 64'h0000_0010_0000_0000) & ~64'hFFF;
    if (a == poison_addr) v = v | 64'h40;
    return v;
  endfunction

  task automatic push_exp(input logic [63:0] a, input logic [31:0] l);
    exp_addr[exp_n] = a;
    exp_len[exp_n]  = l;
    exp_n++;
  endtask

  // Expected segments straight from the requirements.
  task automatic build_expect(input logic [63:0] p1, input logic [63:0] p2, input logic [31:0] len);
    logic [31:0] rem, l;
    logic [63:0] la, e;
    exp_n = 0; exp_err = 1'b0;
    if (len == 0) return;
    if (p1[1:0] != 0) begin exp_err = 1'b1; return; end
    rem = len;
    l = PAGE - (p1 % PAGE);
    if (rem < l) l = rem;
    push_exp(p1, l);
    rem -= l;
    if (rem == 0) return;
    if (rem <= PAGE) begin
      if (p2 % PAGE != 0) begin exp_err = 1'b1; return; end
      push_exp(p2, rem);
      return;
    end
    if (p2[2:0] != 0) begin exp_err = 1'b1; return; end
    la = p2;
    while (rem > 0) begin
      e = mem_at(la);
      if ((la % PAGE) == PAGE - 8 && rem > PAGE) begin
        if (e[2:0] != 0) begin exp_err = 1'b1; return; end
        la = e;
      end else begin
        if (e % PAGE != 0) begin exp_err = 1'b1; return; end
        l = (rem < PAGE) ? rem : PAGE;
        push_exp(e, l);
        rem -= l;
        la += 8;
      end
    end
  endtask

  task automatic check(input logic ok, input string rtag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rtag, what, act, expv);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Port responder and collector, all at the falling edge.
  initial begin : responder
    logic [15:0] lfsr;
    logic        pend;
    int          wait_n;
    logic [63:0] pend_addr;
    lfsr = 16'hACE1; pend = 1'b0; wait_n = 0; pend_addr = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (done) begin saw_done = 1'b1; end_cyc = cyc; end
      if (err)  saw_err = 1'b1;
      lrd_rsp_valid = 1'b0;
      if (pend) begin
        if (wait_n == 0) begin
          lrd_rsp_valid = 1'b1;
          lrd_rsp_data  = mem_at(pend_addr);
          pend = 1'b0;
        end else wait_n--;
      end
      seg_ready = lfsr[0] | lfsr[3];
      if (seg_valid && seg_ready && got_n < MAXS) begin
        got_addr[got_n] = seg_addr;
        got_len[got_n]  = seg_len;
        got_n++;
        last_hs_cyc = cyc;
      end
      lrd_req_ready = lfsr[5] | lfsr[9];
      if (lrd_req_valid && lrd_req_ready && !pend) begin
        pend = 1'b1;
        pend_addr = lrd_req_addr;
        wait_n = int'(lfsr[8:7]);
      end
    end
  end

  task automatic run_case(input logic [63:0] p1, input logic [63:0] p2, input logic [31:0] len,
                          input string rtag, input logic intrude);
    int n_bad;
    build_expect(p1, p2, len);
    @(negedge clk);
    got_n = 0; saw_done = 1'b0; saw_err = 1'b0;
    start = 1'b1; ptr_first = p1; ptr_second = p2; xfer_len = len;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      check(busy, "R10", "busy before stray start", 64'(busy), 64'd1);
      start = 1'b1; ptr_first = 64'h9999_0002; ptr_second = '0; xfer_len = 32'h10;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 40000 && !saw_done && !saw_err; k++) @(negedge clk);
    check(saw_err == exp_err && (saw_done != exp_err), rtag, "end kind (err)",
          64'(saw_err), 64'(exp_err));
    check(got_n == exp_n, rtag, "segment count", 64'(got_n), 64'(exp_n));
    n_bad = 0;
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      if (got_addr[i] !== exp_addr[i] || got_len[i] !== exp_len[i]) begin
        if (n_bad == 0)
          check(1'b0, rtag, $sformatf("segment %0d addr/len", i),
                {got_addr[i][47:0], got_len[i][15:0]}, {exp_addr[i][47:0], exp_len[i][15:0]});
        n_bad++;
      end
    end
    if (n_bad == 0) check(1'b1, rtag, "segments", 0, 0);
    if (!exp_err && exp_n > 0)
      check(end_cyc - last_hs_cyc == 1, "R8", "done one cycle after last handshake",
            64'(end_cyc - last_hs_cyc), 64'd1);
    @(negedge clk);
    check(!busy, rtag, "idle after end", 64'(busy), 64'd0);
  endtask

  typedef struct packed {
    logic [63:0] p1;
    logic [63:0] p2;
    logic [31:0] len;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'h1000_0100, 64'h0,         32'h200},   // R2 inside one page
    '{64'h2000_0F00, 64'h3000_0000, 32'h800},   // R4 spill into second page
    '{64'h2000_0000, 64'h3000_0000, 32'h2000},  // R4 exactly two pages
    '{64'h4000_0800, 64'h5000_0000, 32'h3000},  // R5 list
    '{64'h4000_0000, 64'h6000_0FE0, 32'h8000},  // R6 early chain
    '{64'h1000_0FFC, 64'h3000_1000, 32'h8},     // R3 four bytes before boundary
    '{64'h1000_0002, 64'h3000_0000, 32'h100},   // R1 misaligned first
    '{64'h1000_0000, 64'h3000_0040, 32'h1800},  // R7 second pointer mid-page
    '{64'h1000_0000, 64'h5000_0004, 32'h3000},  // R7 list address misaligned
    '{64'h1000_0000, 64'h3000_0000, 32'h0}      // R8 zero length
  };

  function automatic string rtag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R4";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R3";
      6: return "R1";
      7: return "R7";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !seg_valid && !lrd_req_valid && !done && !err, "R9", "reset outputs quiet",
          {59'd0, busy, seg_valid, lrd_req_valid, done, err}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_case(VECS[i].p1, VECS[i].p2, VECS[i].len, rtag_of(i), 1'b0);

    // R6: a full list page, chaining at its final slot
    run_case(64'h0800_0000, 64'h7000_0000, 32'd600 * PAGE, "R6", 1'b0);
    // R3: mid-page first pointer followed by many whole pages
    run_case(64'h0800_0A00, 64'h7100_0000, 32'h5123, "R3", 1'b0);
    // R7: a listed data pointer with a page offset
    poison_addr = 64'h5200_0010;
    run_case(64'h0900_0000, 64'h5200_0000, 32'h6000, "R7", 1'b0);
    poison_addr = '1;
    // R10: stray start while running
    run_case(64'h4000_0000, 64'h6000_0FE0, 32'h8000, "R10", 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule